// File: doc/BRIEF.md
# Reconfiguration Port Register Bridge

This block sits between a 32-bit host register interface and the 16-bit dynamic reconfiguration port of a clock synthesizer. Software uses it to release the core reset, enable the synthesizer, pick the clock source, and read or write single synthesizer registers through the port.

One write to the control register starts a port access. That word carries the go flag, the read flag, the port register address and, for writes, the data. While the access is in flight, a busy flag is set in the status register. When the access completes, busy drops. After a read, the returned data stays in the status register until the next read completes.

The host interface is a plain strobe interface with no back-pressure. Software must keep to the protocol: poll status until busy is clear before it writes the next control word. The bridge ignores a control word that arrives while busy is set. On the port side there is one select pulse per access, and the bridge waits for the port's ready strobe, however many cycles that takes. Ready is a completion strobe and not a flow-control handshake, so the bridge never stalls the host.

Top module: `recfg_port_bridge`

## Requirements
- R1: After reset, every mapped register reads as zero, status busy (bit 16) is clear, `prt_sel`, `core_rst_release`, `synth_enable` and `clk_src_sel` are low.
- R2: Offset 0x40 holds two bits. Bit 0 drives `core_rst_release` and bit 1 drives `synth_enable`. Both bits read back in place, and the upper bits read as zero. The register changes only when written.
- R3: Offset 0x44 stores the low `SRC_SEL_W` bits written, drives them on `clk_src_sel`, and reads them back with the upper bits zero.
- R4: A write to offset 0x70 with bit 29 set while idle has these effects:
  - Busy reads as set from the next cycle.
  - `prt_sel` is high for exactly one cycle.
  - `prt_we` is high with `prt_sel` only when bit 28 is clear.
  - `prt_addr` equals word bits 22:16.
  - `prt_wdata` equals word bits 15:0.
- R5: Busy clears on the clock edge at which `prt_rdy` is sampled high. If the access was a read, status bits 15:0 take `prt_rdata` at that edge. Write accesses leave bits 15:0 unchanged.
- R6: A control write that arrives while busy is set is ignored. It starts no port access and does not change the access in flight.
- R7: A control write with bit 29 clear starts no port access, and busy stays clear.
- R8: Control bits 27:23 are ignored. Only bits 22:16 reach the 7-bit port address.
- R9: Reads of any offset other than 0x40, 0x44 and 0x74 return zero, and the control register at 0x70 is write-only. Writes to unmapped offsets change no register or output.
- R10: Read data is registered. `host_rdata` updates on the edge that samples `host_rd_en` and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | HOST_AW | Byte offset of the register |
| host_wdata | input | HOST_DW | Host write data |
| host_rdata | output | HOST_DW | Registered host read data |
| core_rst_release | output | 1 | Reset release, bit 0 of 0x40 |
| synth_enable | output | 1 | Synthesizer enable, bit 1 of 0x40 |
| clk_src_sel | output | SRC_SEL_W | Clock source select |
| prt_sel | output | 1 | Port access strobe, one cycle |
| prt_we | output | 1 | Port write enable, valid with prt_sel |
| prt_addr | output | PORT_AW | Port register address |
| prt_wdata | output | PORT_DW | Port write data |
| prt_rdata | input | PORT_DW | Port read data, valid with prt_rdy |
| prt_rdy | input | 1 | Port completion strobe |

## Verification
The assertions check the following on every cycle:
- The select strobe is a single-cycle pulse that only occurs with busy set.
- A control write during busy never produces a select.
- Busy falls on the cycle after ready.
- Status data moves only on a read completion.
- The reset register moves only on a write.
- Unmapped reads return zero.

Only the bench scenarios can show the data-level behaviour, because that needs a model of the port's contents: that read data matches what was earlier written through the port over varying ready latencies, that the address field drops bits 27:23, that an ignored control word leaves its target port register untouched, and that read data is registered.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam logic [7:0] OFS_RESET  = 8'h40;
  localparam logic [7:0] OFS_SRCSEL = 8'h44;
  localparam logic [7:0] OFS_CTRL   = 8'h70;
  localparam logic [7:0] OFS_STAT   = 8'h74;

  localparam int CTRL_GO_BIT    = 29;
  localparam int CTRL_RD_BIT    = 28;
  localparam int CTRL_ADDR_LSB  = 16;
  localparam int STAT_BUSY_BIT  = 16;
  localparam int RST_REL_BIT    = 0;
  localparam int RST_EN_BIT     = 1;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_RESET,
    REG_SRCSEL,
    REG_CTRL,
    REG_STAT
  } reg_sel_e;
endpackage

// File: rtl/recfg_cfg_regs.sv
module recfg_cfg_regs
  import recfg_pkg::*;
#(
  parameter int HOST_DW   = 32,
  parameter int SRC_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_reset,
  input  logic                 wr_src,
  input  logic [HOST_DW-1:0]   wdata,
  output logic [1:0]           rst_bits,
  output logic [SRC_SEL_W-1:0] src_sel
);
  logic [1:0]           rst_q;
  logic [SRC_SEL_W-1:0] src_q;
  logic                 wdata_unused;

  assign wdata_unused = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= '0;
      src_q <= '0;
    end else begin
      if (wr_reset) begin
        rst_q[RST_REL_BIT] <= wdata[RST_REL_BIT];
        rst_q[RST_EN_BIT]  <= wdata[RST_EN_BIT];
      end
      if (wr_src) src_q <= wdata[SRC_SEL_W-1:0];
    end
  end

  assign rst_bits = rst_q;
  assign src_sel  = src_q;

  // R2
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_reset |=> $stable(rst_bits));

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_src |=> $stable(src_sel));
endmodule

// File: rtl/recfg_port_seq.sv
module recfg_port_seq
  import recfg_pkg::*;
#(
  parameter int HOST_DW = 32,
  parameter int PORT_AW = 7,
  parameter int PORT_DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic [HOST_DW-1:0] ctrl_word,
  output logic               prt_sel,
  output logic               prt_we,
  output logic [PORT_AW-1:0] prt_addr,
  output logic [PORT_DW-1:0] prt_wdata,
  input  logic [PORT_DW-1:0] prt_rdata,
  input  logic               prt_rdy,
  output logic               busy,
  output logic [PORT_DW-1:0] rd_data
);
  localparam int ADDR_MSB = CTRL_ADDR_LSB + PORT_AW - 1;

  logic               busy_q;
  logic               sel_q;
  logic               we_q;
  logic               pend_rd_q;
  logic [PORT_AW-1:0] addr_q;
  logic [PORT_DW-1:0] wdata_q;
  logic [PORT_DW-1:0] rd_data_q;
  logic               launch;
  logic               word_unused;

  assign word_unused = ^ctrl_word;
  assign launch      = ctrl_wr && ctrl_word[CTRL_GO_BIT] && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      sel_q     <= 1'b0;
      we_q      <= 1'b0;
      pend_rd_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_data_q <= '0;
    end else begin
      sel_q <= 1'b0;
      if (busy_q) begin
        if (prt_rdy) begin
          busy_q <= 1'b0;
          if (pend_rd_q) rd_data_q <= prt_rdata;
        end
      end else if (launch) begin
        busy_q    <= 1'b1;
        sel_q     <= 1'b1;
        we_q      <= ~ctrl_word[CTRL_RD_BIT];
        pend_rd_q <= ctrl_word[CTRL_RD_BIT];
        addr_q    <= ctrl_word[ADDR_MSB:CTRL_ADDR_LSB];
        wdata_q   <= ctrl_word[PORT_DW-1:0];
      end
    end
  end

  assign prt_sel   = sel_q;
  assign prt_we    = sel_q & we_q;
  assign prt_addr  = addr_q;
  assign prt_wdata = wdata_q;
  assign busy      = busy_q;
  assign rd_data   = rd_data_q;

  // R4
  sel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prt_sel |=> !prt_sel);

  // R4
  sel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prt_sel |-> busy);

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> !prt_sel);

  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && prt_rdy) |=> !busy);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && prt_rdy && pend_rd_q) |=> $stable(rd_data));
endmodule

// File: rtl/recfg_port_bridge.sv
module recfg_port_bridge
  import recfg_pkg::*;
#(
  parameter int HOST_AW   = 8,
  parameter int HOST_DW   = 32,
  parameter int PORT_AW   = 7,
  parameter int PORT_DW   = 16,
  parameter int SRC_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr_en,
  input  logic                 host_rd_en,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic [HOST_DW-1:0]   host_wdata,
  output logic [HOST_DW-1:0]   host_rdata,
  output logic                 core_rst_release,
  output logic                 synth_enable,
  output logic [SRC_SEL_W-1:0] clk_src_sel,
  output logic                 prt_sel,
  output logic                 prt_we,
  output logic [PORT_AW-1:0]   prt_addr,
  output logic [PORT_DW-1:0]   prt_wdata,
  input  logic [PORT_DW-1:0]   prt_rdata,
  input  logic                 prt_rdy
);
  reg_sel_e             sel;
  logic [1:0]           rst_bits;
  logic                 busy;
  logic [PORT_DW-1:0]   rd_data;
  logic [HOST_DW-1:0]   rd_next;
  logic [HOST_DW-1:0]   rdata_q;

  always_comb begin
    if      (host_addr == HOST_AW'(OFS_RESET))  sel = REG_RESET;
    else if (host_addr == HOST_AW'(OFS_SRCSEL)) sel = REG_SRCSEL;
    else if (host_addr == HOST_AW'(OFS_CTRL))   sel = REG_CTRL;
    else if (host_addr == HOST_AW'(OFS_STAT))   sel = REG_STAT;
    else                                        sel = REG_NONE;
  end

  recfg_cfg_regs #(
    .HOST_DW   (HOST_DW),
    .SRC_SEL_W (SRC_SEL_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_reset (host_wr_en && (sel == REG_RESET)),
    .wr_src   (host_wr_en && (sel == REG_SRCSEL)),
    .wdata    (host_wdata),
    .rst_bits (rst_bits),
    .src_sel  (clk_src_sel)
  );

  recfg_port_seq #(
    .HOST_DW (HOST_DW),
    .PORT_AW (PORT_AW),
    .PORT_DW (PORT_DW)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (host_wr_en && (sel == REG_CTRL)),
    .ctrl_word (host_wdata),
    .prt_sel   (prt_sel),
    .prt_we    (prt_we),
    .prt_addr  (prt_addr),
    .prt_wdata (prt_wdata),
    .prt_rdata (prt_rdata),
    .prt_rdy   (prt_rdy),
    .busy      (busy),
    .rd_data   (rd_data)
  );

  assign core_rst_release = rst_bits[RST_REL_BIT];
  assign synth_enable     = rst_bits[RST_EN_BIT];

  always_comb begin
    rd_next = '0;
    case (sel)
      REG_RESET:  rd_next[1:0] = rst_bits;
      REG_SRCSEL: rd_next[SRC_SEL_W-1:0] = clk_src_sel;
      REG_STAT: begin
        rd_next[PORT_DW-1:0]  = rd_data;
        rd_next[STAT_BUSY_BIT] = busy;
      end
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (host_rd_en) rdata_q <= rd_next;
  end

  assign host_rdata = rdata_q;

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && (sel == REG_NONE || sel == REG_CTRL)) |=> (host_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_en |=> $stable(host_rdata));
endmodule

// File: tb/tb_recfg_port_bridge.sv
`timescale 1ns/1ps
module tb_recfg_port_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic        host_rd_en = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        core_rst_release, synth_enable;
  logic [2:0]  clk_src_sel;
  logic        prt_sel, prt_we;
  logic [6:0]  prt_addr;
  logic [15:0] prt_wdata;
  logic [15:0] prt_rdata = '0;
  logic        prt_rdy = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  recfg_port_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_rst_release(core_rst_release), .synth_enable(synth_enable),
    .clk_src_sel(clk_src_sel), .prt_sel(prt_sel), .prt_we(prt_we),
    .prt_addr(prt_addr), .prt_wdata(prt_wdata), .prt_rdata(prt_rdata),
    .prt_rdy(prt_rdy)
  );

  // Port model: register file with programmable ready latency (>=1)
  logic [15:0] pmem [128];
  int          lat_cfg = 1;
  int          cnt = 0;
  bit          pending = 0;
  logic [6:0]  p_addr = '0;
  int          sel_count = 0;
  bit          sel_wide = 0;
  bit          sel_prev = 0;
  logic [6:0]  last_addr = '0;
  logic        last_we = 1'b0;
  logic [15:0] last_wdata = '0;

  initial for (int i = 0; i < 128; i++) pmem[i] = '0;

  always @(posedge clk) begin
    prt_rdy <= 1'b0;
    if (prt_sel) begin
      sel_count  <= sel_count + 1;
      last_addr  <= prt_addr;
      last_we    <= prt_we;
      last_wdata <= prt_wdata;
      if (prt_we) pmem[prt_addr] <= prt_wdata;
      p_addr  <= prt_addr;
      cnt     <= lat_cfg;
      pending <= 1;
    end else if (pending) begin
      if (cnt <= 1) begin
        prt_rdy   <= 1'b1;
        prt_rdata <= pmem[p_addr];
        pending   <= 0;
      end else cnt <= cnt - 1;
    end
    if (prt_sel && sel_prev) sel_wide <= 1;
    sel_prev <= prt_sel;
  end

  logic [15:0] exp_mem [128];
  initial for (int i = 0; i < 128; i++) exp_mem[i] = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h0001_0000;
    for (int k = 0; k < 60 && st[16]; k++) host_read(8'h74, st);
  endtask

  function automatic logic [31:0] ctrl(bit rd, logic [6:0] a, logic [15:0] d);
    return (32'd1 << 29) | (32'(rd) << 28) | (32'(a) << 16) | 32'(d);
  endfunction

  // {is_read, addr[6:0], data[15:0], latency[3:0]}
  localparam int NV = 9;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 7'h05, 16'hA5A5, 4'd1},
    {1'b0, 7'h11, 16'h1234, 4'd3},
    {1'b1, 7'h05, 16'h0000, 4'd2},
    {1'b0, 7'h7F, 16'hFFFF, 4'd5},
    {1'b1, 7'h11, 16'h0000, 4'd1},
    {1'b1, 7'h7F, 16'h0000, 4'd4},
    {1'b0, 7'h05, 16'h0001, 4'd2},
    {1'b1, 7'h05, 16'h0000, 4'd3},
    {1'b1, 7'h22, 16'h0000, 4'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, st;
    logic [15:0] last_rd;
    int          sc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 prt_sel", 32'(prt_sel), 0);
    chk("R1 outputs", {27'd0, core_rst_release, synth_enable, clk_src_sel}, 0);
    host_read(8'h40, rv); chk("R1 reset reg", rv, 0);
    host_read(8'h44, rv); chk("R1 srcsel reg", rv, 0);
    host_read(8'h74, rv); chk("R1 status", rv, 0);

    // R2 reset register
    host_write(8'h40, 32'hFFFF_FFFE);
    chk("R2 release", 32'(core_rst_release), 0);
    chk("R2 enable", 32'(synth_enable), 1);
    host_read(8'h40, rv); chk("R2 readback", rv, 32'h2);
    host_write(8'h40, 32'h1);
    chk("R2 outputs", {30'd0, synth_enable, core_rst_release}, 32'h1);

    // R3 source select
    host_write(8'h44, 32'hFFFF_FFF5);
    chk("R3 output", 32'(clk_src_sel), 32'h5);
    host_read(8'h44, rv); chk("R3 readback", rv, 32'h5);

    // R10 registered read: value must not move before the edge
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = 8'h40;
    #1 chk("R10 before edge", host_rdata, 32'h5);
    @(negedge clk);
    host_rd_en = 1'b0;
    chk("R10 after edge", host_rdata, 32'h1);
    @(negedge clk);
    chk("R10 hold", host_rdata, 32'h1);

    // R9 unmapped offsets and write-only control
    host_write(8'h48, 32'hFFFF_FFFF);
    host_write(8'h00, 32'hFFFF_FFFF);
    host_read(8'h48, rv); chk("R9 unmapped read", rv, 0);
    host_read(8'h70, rv); chk("R9 ctrl reads zero", rv, 0);
    host_read(8'h40, rv); chk("R9 reset reg untouched", rv, 32'h1);
    host_read(8'h44, rv); chk("R9 srcsel untouched", rv, 32'h5);
    chk("R9 prt_sel idle", 32'(sel_count), 0);

    // Vector table: R4/R5
    last_rd = '0;
    for (int v = 0; v < NV; v++) begin
      bit          is_rd;
      logic [6:0]  a;
      logic [15:0] d;
      is_rd   = VEC[v][27];
      a       = VEC[v][26:20];
      d       = VEC[v][19:4];
      lat_cfg = int'(VEC[v][3:0]);
      sc      = sel_count;
      host_write(8'h70, ctrl(is_rd, a, d));
      host_read(8'h74, st);
      chk("R4 busy set", 32'(st[16]), 1);
      chk("R4 one select", 32'(sel_count - sc), 1);
      chk("R4 address", 32'(last_addr), 32'(a));
      chk("R4 we", 32'(last_we), 32'(!is_rd));
      if (!is_rd) begin
        chk("R4 wdata", 32'(last_wdata), 32'(d));
        exp_mem[a] = d;
      end
      wait_idle(st);
      chk("R5 busy clear", 32'(st[16]), 0);
      if (is_rd) last_rd = exp_mem[a];
      chk("R5 status data", 32'(st[15:0]), 32'(last_rd));
    end
    chk("R4 select width", 32'(sel_wide), 0);

    // R6 control write while busy ignored
    lat_cfg = 8;
    sc = sel_count;
    host_write(8'h70, ctrl(0, 7'h30, 16'hBEEF));
    host_write(8'h70, ctrl(0, 7'h31, 16'h4444));
    wait_idle(st);
    chk("R6 single access", 32'(sel_count - sc), 1);
    chk("R6 first target", 32'(last_addr), 32'h30);
    lat_cfg = 2;
    host_write(8'h70, ctrl(1, 7'h31, 16'h0));
    wait_idle(st);
    chk("R6 second not written", 32'(st[15:0]), 0);
    host_write(8'h70, ctrl(1, 7'h30, 16'h0));
    wait_idle(st);
    chk("R6 first written", 32'(st[15:0]), 32'hBEEF);

    // R7 go bit clear
    sc = sel_count;
    host_write(8'h70, 32'h0005_9999);
    host_read(8'h74, st);
    chk("R7 busy stays clear", 32'(st[16]), 0);
    repeat (5) @(negedge clk);
    chk("R7 no access", 32'(sel_count - sc), 0);
    host_write(8'h70, ctrl(1, 7'h05, 16'h0));
    wait_idle(st);
    chk("R7 port reg unchanged", 32'(st[15:0]), 32'h0001);

    // R8 high address bits ignored
    host_write(8'h70, ctrl(0, 7'h15, 16'h7777) | (32'h1F << 23));
    wait_idle(st);
    chk("R8 address", 32'(last_addr), 32'h15);
    host_write(8'h70, ctrl(1, 7'h15, 16'h0));
    wait_idle(st);
    chk("R8 data landed", 32'(st[15:0]), 32'h7777);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule